// File: doc/BRIEF.md
# Dataflow Operand-Firing Instruction Window

This block is the instruction window of one execution tile in a dataflow machine. A compiler places each instruction into a fixed slot before run time. The hardware then decides when it runs. An instruction fires once every operand it needs has been written into its slot. Results never pass through a register file. Each slot names up to two consumers, written as a (slot, operand index) pair. When the ALU returns a result for a slot, the window sends that result out tagged with those consumer targets. The tile's routing, which is outside this block, delivers each target either back into a local slot or to another tile.

An instruction may be predicated. It then waits for its predicate operand as well. If the predicate disagrees with the expected polarity, the slot retires silently and never issues. When several slots are ready in the same cycle, the lowest-numbered slot issues, and only one slot issues per cycle. A write to an operand that already holds a value since the last flush raises a protocol-error pulse. A flush input empties the whole window in one cycle.

Top module: `dfw_station`

## Requirements
- R1: Reset or `flush` clears every loaded, done and operand-present flag in one cycle. While `flush` is high, `iss_valid` is low, and any load, operand write or ALU return in that cycle is discarded. In the cycle after a flush, `iss_valid`, `prot_err` and `res_valid` are all low.
- R2: A loaded slot issues only when each operand it uses (left if `ld_use_left`, right if `ld_use_right`) has been written. A slot that uses neither operand and is unpredicated can issue in the cycle after its load.
- R3: An issue presents the slot number, its opcode, its stored left and right values, and `iss_valid` high, combinationally in the cycle after the operand or load edge that made the slot ready. The issuing edge retires the slot, so it issues exactly once per load.
- R4: A predicated slot (`ld_pred_en`) also needs its predicate. The predicate arrives as an operand write with index 2, and its value is bit 0 of the data. If that bit equals `ld_pred_pol`, the slot may issue. Otherwise it retires at the next edge and never issues.
- R5: When several slots are ready, the lowest slot index issues first. At most one slot issues per cycle.
- R6: Operand index encoding: 0 left, 1 right, 2 predicate, 3 reserved. A write with index 3, or a write to an operand already present, is ignored and leaves the stored value unchanged. It raises `prot_err` for one cycle, on the cycle after the write.
- R7: An ALU return (`alu_valid`, `alu_slot`, `alu_data`) produces `res_valid[k]` one cycle later for each enabled target k of that slot. Target k's slot sits at `res_slot[k*6 +: 6]` and its operand index at `res_idx[k*2 +: 2]`. Both targets carry `res_data` equal to `alu_data`.
- R8: Operands written to a slot before its instruction is loaded are kept, and they count toward readiness once the slot is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the window |
| ld_valid | input | 1 | Instruction load strobe |
| ld_slot | input | 6 | Slot receiving the instruction |
| ld_opcode | input | 8 | Opcode |
| ld_use_left | input | 1 | Instruction needs a left operand |
| ld_use_right | input | 1 | Instruction needs a right operand |
| ld_pred_en | input | 1 | Instruction is predicated |
| ld_pred_pol | input | 1 | Predicate value that enables execution |
| ld_t0_en | input | 1 | Target 0 present |
| ld_t0_slot | input | 6 | Target 0 consumer slot |
| ld_t0_idx | input | 2 | Target 0 operand index |
| ld_t1_en | input | 1 | Target 1 present |
| ld_t1_slot | input | 6 | Target 1 consumer slot |
| ld_t1_idx | input | 2 | Target 1 operand index |
| opw_valid | input | 1 | Operand write strobe |
| opw_slot | input | 6 | Slot written |
| opw_idx | input | 2 | Operand index (0 left, 1 right, 2 predicate, 3 reserved) |
| opw_data | input | 32 | Operand value |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_slot | output | 6 | Issuing slot |
| iss_opcode | output | 8 | Issuing opcode |
| iss_left | output | 32 | Left operand |
| iss_right | output | 32 | Right operand |
| alu_valid | input | 1 | ALU result return |
| alu_slot | input | 6 | Slot whose result returns |
| alu_data | input | 32 | Result value |
| res_valid | output | 2 | Outgoing result per target |
| res_slot | output | 12 | Consumer slots, 6 bits per target |
| res_idx | output | 4 | Consumer operand indices, 2 bits per target |
| res_data | output | 32 | Outgoing result value |
| prot_err | output | 1 | Protocol-error pulse |

## Verification
Several rules are checked by the assertions on every cycle. An issuing slot must have its used operands present, and a matching predicate if it is predicated. A slot that issues is no longer ready afterwards. No ready slot may sit below the one issuing. A rejected write must leave the stored operand unchanged. A flush must leave the outputs quiet, and result and error pulses must follow their cause by one cycle.

Other behaviour can only be shown by the bench's scenarios, which compare against a reference model every cycle. These cover the ordering among slots that become ready in the same cycle, operands kept from before a load, squashed predicates never issuing, loads and writes discarded under flush, and the exact target tags on returned results.

// File: rtl/dfw_pkg.sv
package dfw_pkg;
  parameter int NSLOT  = 64;
  parameter int DATA_W = 32;
  parameter int OPC_W  = 8;
  parameter int NTGT   = 2;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int IDX_W  = 2;

  localparam logic [IDX_W-1:0] OP_LEFT  = 2'd0;
  localparam logic [IDX_W-1:0] OP_RIGHT = 2'd1;
  localparam logic [IDX_W-1:0] OP_PRED  = 2'd2;
  localparam logic [IDX_W-1:0] OP_RSVD  = 2'd3;

  typedef struct packed {
    logic              en;
    logic [SLOT_W-1:0] slot;
    logic [IDX_W-1:0]  idx;
  } tgt_t;

  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic             use_l;
    logic             use_r;
    logic             pred_en;
    logic             pred_pol;
    tgt_t             t0;
    tgt_t             t1;
  } instr_t;

  // A slot may fire when loaded, not retired, operands in, predicate agrees.
  function automatic logic slot_ready(input instr_t i, input logic loaded,
                                      input logic done, input logic lv,
                                      input logic rv, input logic pv,
                                      input logic pval);
    return loaded && !done && (!i.use_l || lv) && (!i.use_r || rv) &&
           (!i.pred_en || (pv && (pval == i.pred_pol)));
  endfunction

  // A predicated slot whose predicate disagrees retires without firing.
  function automatic logic slot_squash(input instr_t i, input logic loaded,
                                       input logic done, input logic pv,
                                       input logic pval);
    return loaded && !done && i.pred_en && pv && (pval != i.pred_pol);
  endfunction

  // Reserved index or an operand that is already present.
  function automatic logic opnd_clash(input logic [IDX_W-1:0] idx, input logic lv,
                                      input logic rv, input logic pv);
    return (idx == OP_RSVD) || (idx == OP_LEFT && lv) ||
           (idx == OP_RIGHT && rv) || (idx == OP_PRED && pv);
  endfunction

  // {found, index} of the lowest set bit.
  function automatic logic [SLOT_W:0] lowest_set(input logic [NSLOT-1:0] v);
    logic [SLOT_W:0] r;
    r = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, SLOT_W'(i)};
    return r;
  endfunction
endpackage

// File: rtl/dfw_slot.sv
module dfw_slot
  import dfw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              ld_hit,
  input  instr_t            ld_instr,
  input  logic              wr_hit,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output instr_t            instr,
  output logic              ready,
  output logic              wr_err,
  output logic [DATA_W-1:0] l_data,
  output logic [DATA_W-1:0] r_data
);
  logic loaded, done, lv, rv, pv, pval;
  logic squash, wr_ok;

  assign wr_err = wr_hit && opnd_clash(wr_idx, lv, rv, pv);
  assign wr_ok  = wr_hit && !wr_err;
  assign ready  = slot_ready(instr, loaded, done, lv, rv, pv, pval);
  assign squash = slot_squash(instr, loaded, done, pv, pval);

  // Presence and state flags: flush wins over everything.
  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      loaded <= 1'b0;
      done   <= 1'b0;
      lv     <= 1'b0;
      rv     <= 1'b0;
      pv     <= 1'b0;
    end else begin
      if (wr_ok && wr_idx == OP_LEFT)  lv <= 1'b1;
      if (wr_ok && wr_idx == OP_RIGHT) rv <= 1'b1;
      if (wr_ok && wr_idx == OP_PRED)  pv <= 1'b1;
      if (ld_hit) begin
        loaded <= 1'b1;
        done   <= 1'b0;
      end else if (take || squash) begin
        done <= 1'b1;
      end
    end
  end

  // Payload storage: reset only, untouched by flush.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      instr  <= '0;
      l_data <= '0;
      r_data <= '0;
      pval   <= 1'b0;
    end else if (!flush) begin
      if (ld_hit) instr <= ld_instr;
      if (wr_ok && wr_idx == OP_LEFT)  l_data <= wr_data;
      if (wr_ok && wr_idx == OP_RIGHT) r_data <= wr_data;
      if (wr_ok && wr_idx == OP_PRED)  pval   <= wr_data[0];
    end
  end

  // R2
  fire_needs_opnd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ((!instr.use_l || lv) && (!instr.use_r || rv)));
  // R4
  fire_pred_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && instr.pred_en) |-> (pv && pval == instr.pred_pol));
  // R3
  fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ld_hit && !flush) |=> !ready);
  // R6
  clash_keeps_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && wr_idx == OP_LEFT) |=> $stable(l_data));
endmodule

// File: rtl/dfw_pick.sv
module dfw_pick
  import dfw_pkg::*;
(
  input  logic [NSLOT-1:0]  req,
  output logic              found,
  output logic [SLOT_W-1:0] idx
);
  logic [SLOT_W:0] sel;
  assign sel   = lowest_set(req);
  assign found = sel[SLOT_W];
  assign idx   = sel[SLOT_W-1:0];
endmodule

// File: rtl/dfw_route.sv
module dfw_route
  import dfw_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   alu_valid,
  input  logic [DATA_W-1:0]      alu_data,
  input  tgt_t                   tgt [NTGT],
  output logic [NTGT-1:0]        res_valid,
  output logic [NTGT*SLOT_W-1:0] res_slot,
  output logic [NTGT*IDX_W-1:0]  res_idx,
  output logic [DATA_W-1:0]      res_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_data <= '0;
    end else if (alu_valid && !flush) begin
      res_data <= alu_data;
    end
  end

  for (genvar k = 0; k < NTGT; k++) begin : g_tgt
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        res_valid[k] <= 1'b0;
      end else begin
        res_valid[k] <= alu_valid && tgt[k].en;
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_slot[k*SLOT_W +: SLOT_W] <= '0;
        res_idx[k*IDX_W +: IDX_W]    <= '0;
      end else if (alu_valid && !flush) begin
        res_slot[k*SLOT_W +: SLOT_W] <= tgt[k].slot;
        res_idx[k*IDX_W +: IDX_W]    <= tgt[k].idx;
      end
    end
  end
endmodule

// File: rtl/dfw_station.sv
module dfw_station
  import dfw_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   ld_valid,
  input  logic [SLOT_W-1:0]      ld_slot,
  input  logic [OPC_W-1:0]       ld_opcode,
  input  logic                   ld_use_left,
  input  logic                   ld_use_right,
  input  logic                   ld_pred_en,
  input  logic                   ld_pred_pol,
  input  logic                   ld_t0_en,
  input  logic [SLOT_W-1:0]      ld_t0_slot,
  input  logic [IDX_W-1:0]       ld_t0_idx,
  input  logic                   ld_t1_en,
  input  logic [SLOT_W-1:0]      ld_t1_slot,
  input  logic [IDX_W-1:0]       ld_t1_idx,
  input  logic                   opw_valid,
  input  logic [SLOT_W-1:0]      opw_slot,
  input  logic [IDX_W-1:0]       opw_idx,
  input  logic [DATA_W-1:0]      opw_data,
  output logic                   iss_valid,
  output logic [SLOT_W-1:0]      iss_slot,
  output logic [OPC_W-1:0]       iss_opcode,
  output logic [DATA_W-1:0]      iss_left,
  output logic [DATA_W-1:0]      iss_right,
  input  logic                   alu_valid,
  input  logic [SLOT_W-1:0]      alu_slot,
  input  logic [DATA_W-1:0]      alu_data,
  output logic [NTGT-1:0]        res_valid,
  output logic [NTGT*SLOT_W-1:0] res_slot,
  output logic [NTGT*IDX_W-1:0]  res_idx,
  output logic [DATA_W-1:0]      res_data,
  output logic                   prot_err
);
  instr_t            ld_word;
  instr_t            s_instr [NSLOT];
  logic [DATA_W-1:0] s_left  [NSLOT];
  logic [DATA_W-1:0] s_right [NSLOT];
  logic [NSLOT-1:0]  rdy, werr, take;
  logic              pk_found;
  logic [SLOT_W-1:0] pk_idx;
  tgt_t              ret_tgt [NTGT];

  assign ld_word = '{opc: ld_opcode, use_l: ld_use_left, use_r: ld_use_right,
                     pred_en: ld_pred_en, pred_pol: ld_pred_pol,
                     t0: '{en: ld_t0_en, slot: ld_t0_slot, idx: ld_t0_idx},
                     t1: '{en: ld_t1_en, slot: ld_t1_slot, idx: ld_t1_idx}};

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign take[g] = iss_valid && (pk_idx == SLOT_W'(g));
    dfw_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .ld_hit  (ld_valid && ld_slot == SLOT_W'(g)),
      .ld_instr(ld_word),
      .wr_hit  (opw_valid && opw_slot == SLOT_W'(g)),
      .wr_idx  (opw_idx),
      .wr_data (opw_data),
      .take    (take[g]),
      .instr   (s_instr[g]),
      .ready   (rdy[g]),
      .wr_err  (werr[g]),
      .l_data  (s_left[g]),
      .r_data  (s_right[g])
    );
  end

  dfw_pick u_pick (.req(rdy), .found(pk_found), .idx(pk_idx));

  assign iss_valid  = pk_found && !flush;
  assign iss_slot   = pk_idx;
  assign iss_opcode = s_instr[pk_idx].opc;
  assign iss_left   = s_left[pk_idx];
  assign iss_right  = s_right[pk_idx];

  assign ret_tgt[0] = s_instr[alu_slot].t0;
  assign ret_tgt[1] = s_instr[alu_slot].t1;

  dfw_route u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .alu_valid(alu_valid),
    .alu_data (alu_data),
    .tgt      (ret_tgt),
    .res_valid(res_valid),
    .res_slot (res_slot),
    .res_idx  (res_idx),
    .res_data (res_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || flush) prot_err <= 1'b0;
    else                 prot_err <= |werr;
  end

  // R1
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!iss_valid && !prot_err && res_valid == '0));
  // R5
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> ((rdy & ((NSLOT'(1) << iss_slot) - NSLOT'(1))) == '0));
  // R7
  res_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid != '0) |-> $past(alu_valid));
  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |-> $past(opw_valid));
endmodule

// File: tb/dfw_station_tb.sv
`timescale 1ns/1ps
module dfw_station_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush, ld_valid, ld_use_left, ld_use_right, ld_pred_en, ld_pred_pol;
  logic ld_t0_en, ld_t1_en, opw_valid, alu_valid;
  logic [5:0] ld_slot, ld_t0_slot, ld_t1_slot, opw_slot, alu_slot;
  logic [7:0] ld_opcode;
  logic [1:0] ld_t0_idx, ld_t1_idx, opw_idx;
  logic [31:0] opw_data, alu_data;
  logic iss_valid, prot_err;
  logic [5:0] iss_slot;
  logic [7:0] iss_opcode;
  logic [31:0] iss_left, iss_right, res_data;
  logic [1:0] res_valid;
  logic [11:0] res_slot;
  logic [3:0] res_idx;

  always #2 clk = ~clk;

  dfw_station u_dut (.*);

  int n_chk = 0, n_bad = 0;
  bit running = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit m_ld[64], m_dn[64], m_lv[64], m_rv[64], m_pv[64], m_pval[64];
  bit m_ul[64], m_ur[64], m_pe[64], m_pp[64], m_e0[64], m_e1[64];
  logic [7:0]  m_opc[64];
  logic [5:0]  m_s0[64], m_s1[64];
  logic [1:0]  m_i0[64], m_i1[64];
  logic [31:0] m_l[64], m_r[64];
  bit e_err;
  logic [1:0] e_rv;
  logic [5:0] e_s0, e_s1;
  logic [1:0] e_i0, e_i1;
  logic [31:0] e_rd;

  function automatic bit ref_ready(input int i);
    return m_ld[i] && !m_dn[i] && (!m_ul[i] || m_lv[i]) && (!m_ur[i] || m_rv[i]) &&
           (!m_pe[i] || (m_pv[i] && m_pval[i] == m_pp[i]));
  endfunction

  function automatic int ref_pick();
    for (int i = 0; i < 64; i++) if (ref_ready(i)) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    int p;
    bit sq[64];
    if (!rst_n || flush) begin
      for (int i = 0; i < 64; i++) begin
        m_ld[i] = 0; m_dn[i] = 0; m_lv[i] = 0; m_rv[i] = 0; m_pv[i] = 0;
        if (!rst_n) begin
          m_pval[i] = 0; m_ul[i] = 0; m_ur[i] = 0; m_pe[i] = 0; m_pp[i] = 0;
          m_e0[i] = 0; m_e1[i] = 0; m_opc[i] = 0; m_s0[i] = 0; m_s1[i] = 0;
          m_i0[i] = 0; m_i1[i] = 0; m_l[i] = 0; m_r[i] = 0;
        end
      end
      e_err = 0; e_rv = 0;
    end else begin
      p = ref_pick();
      for (int i = 0; i < 64; i++)
        sq[i] = m_ld[i] && !m_dn[i] && m_pe[i] && m_pv[i] && (m_pval[i] != m_pp[i]);
      e_rv = 0;
      if (alu_valid) begin
        e_rv = {m_e1[alu_slot], m_e0[alu_slot]};
        e_s0 = m_s0[alu_slot]; e_i0 = m_i0[alu_slot];
        e_s1 = m_s1[alu_slot]; e_i1 = m_i1[alu_slot];
        e_rd = alu_data;
      end
      e_err = 0;
      if (opw_valid) begin
        case (opw_idx)
          2'd0: if (m_lv[opw_slot]) e_err = 1; else begin m_lv[opw_slot] = 1; m_l[opw_slot] = opw_data; end
          2'd1: if (m_rv[opw_slot]) e_err = 1; else begin m_rv[opw_slot] = 1; m_r[opw_slot] = opw_data; end
          2'd2: if (m_pv[opw_slot]) e_err = 1; else begin m_pv[opw_slot] = 1; m_pval[opw_slot] = opw_data[0]; end
          default: e_err = 1;
        endcase
      end
      for (int i = 0; i < 64; i++) if (sq[i]) m_dn[i] = 1;
      if (p >= 0) m_dn[p] = 1;
      if (ld_valid) begin
        m_ld[ld_slot] = 1; m_dn[ld_slot] = 0;
        m_opc[ld_slot] = ld_opcode; m_ul[ld_slot] = ld_use_left; m_ur[ld_slot] = ld_use_right;
        m_pe[ld_slot] = ld_pred_en; m_pp[ld_slot] = ld_pred_pol;
        m_e0[ld_slot] = ld_t0_en; m_s0[ld_slot] = ld_t0_slot; m_i0[ld_slot] = ld_t0_idx;
        m_e1[ld_slot] = ld_t1_en; m_s1[ld_slot] = ld_t1_slot; m_i1[ld_slot] = ld_t1_idx;
      end
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    int p;
    if (rst_n && running) begin
      p = flush ? -1 : ref_pick();
      check(iss_valid == (p >= 0), "R5 issue valid", int'(iss_valid), (p >= 0) ? 1 : 0);
      if (p >= 0 && iss_valid) begin
        check(iss_slot == 6'(p), "R5 issue slot", int'(iss_slot), p);
        check(iss_opcode == m_opc[p], "R3 issue opcode", int'(iss_opcode), int'(m_opc[p]));
        if (m_ul[p]) check(iss_left == m_l[p], "R3 left value", int'(iss_left), int'(m_l[p]));
        if (m_ur[p]) check(iss_right == m_r[p], "R3 right value", int'(iss_right), int'(m_r[p]));
      end
      check(prot_err == e_err, "R6 error pulse", int'(prot_err), int'(e_err));
      check(res_valid == e_rv, "R7 result valid", int'(res_valid), int'(e_rv));
      if (e_rv[0]) check(res_slot[5:0] == e_s0 && res_idx[1:0] == e_i0 && res_data == e_rd,
                         "R7 target0", int'({res_slot[5:0], res_idx[1:0]}), int'({e_s0, e_i0}));
      if (e_rv[1]) check(res_slot[11:6] == e_s1 && res_idx[3:2] == e_i1 && res_data == e_rd,
                         "R7 target1", int'({res_slot[11:6], res_idx[3:2]}), int'({e_s1, e_i1}));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    flush = 0; ld_valid = 0; opw_valid = 0; alu_valid = 0;
    ld_slot = 0; ld_opcode = 0; ld_use_left = 0; ld_use_right = 0;
    ld_pred_en = 0; ld_pred_pol = 0; ld_t0_en = 0; ld_t0_slot = 0; ld_t0_idx = 0;
    ld_t1_en = 0; ld_t1_slot = 0; ld_t1_idx = 0;
    opw_slot = 0; opw_idx = 0; opw_data = 0; alu_slot = 0; alu_data = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1; idle();
  endtask

  task automatic load(input logic [5:0] s, input logic [7:0] opc, input bit ul, input bit ur,
                      input bit pe, input bit pp);
    ld_valid = 1; ld_slot = s; ld_opcode = opc; ld_use_left = ul; ld_use_right = ur;
    ld_pred_en = pe; ld_pred_pol = pp;
  endtask

  task automatic opw(input logic [5:0] s, input logic [1:0] idx, input logic [31:0] d);
    opw_valid = 1; opw_slot = s; opw_idx = idx; opw_data = d;
  endtask

  task automatic expect_issue(input logic [5:0] s, input string tag);
    check(iss_valid && iss_slot == s, tag, int'({iss_valid, iss_slot}), int'({1'b1, s}));
  endtask

  task automatic expect_none(input string tag);
    check(!iss_valid, tag, int'(iss_valid), 0);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1; running = 1;
    // R1 reset state
    check(!iss_valid && !prot_err && res_valid == 0, "R1 reset outputs quiet",
          int'({iss_valid, prot_err, res_valid}), 0);

    // R2 / R3 two-operand instruction
    load(6'd5, 8'h21, 1, 1, 0, 0);
    ld_t0_en = 1; ld_t0_slot = 6'd17; ld_t0_idx = 2'd0;
    ld_t1_en = 1; ld_t1_slot = 6'd33; ld_t1_idx = 2'd1;
    tick(); expect_none("R2 waits for both operands");
    opw(6'd5, 2'd0, 32'hAAAA0001); tick(); expect_none("R2 waits for right operand");
    opw(6'd5, 2'd1, 32'h0000BEEF); tick();
    expect_issue(6'd5, "R3 issues when ready");
    check(iss_left == 32'hAAAA0001 && iss_right == 32'h0000BEEF && iss_opcode == 8'h21,
          "R3 issue payload", int'(iss_right), 32'h0000BEEF);
    tick(); expect_none("R3 issues once");

    // R7 result routing to two targets
    alu_valid = 1; alu_slot = 6'd5; alu_data = 32'hC0DE0005; tick();
    check(res_valid == 2'b11 && res_slot == {6'd33, 6'd17} && res_idx == {2'd1, 2'd0}
          && res_data == 32'hC0DE0005, "R7 two targets tagged", int'(res_slot), int'({6'd33, 6'd17}));

    // R4 predicate mismatch squashes, match fires
    load(6'd9, 8'h30, 0, 0, 1, 1); tick(); expect_none("R4 waits for predicate");
    opw(6'd9, 2'd2, 32'h0); tick(); expect_none("R4 mismatched predicate");
    tick(); expect_none("R4 squashed slot stays silent");
    load(6'd10, 8'h31, 0, 0, 1, 1); tick();
    opw(6'd10, 2'd2, 32'h1); tick(); expect_issue(6'd10, "R4 matching predicate fires");
    tick();

    // R8 operand before load
    opw(6'd14, 2'd0, 32'h1234); tick(); expect_none("R8 unloaded slot silent");
    load(6'd14, 8'h40, 1, 0, 0, 0); tick();
    expect_issue(6'd14, "R8 early operand kept");
    check(iss_left == 32'h1234, "R8 early operand value", int'(iss_left), 32'h1234);
    tick();

    // R6 protocol errors
    load(6'd50, 8'h50, 1, 1, 0, 0); tick();
    opw(6'd50, 2'd0, 32'h11); tick(); check(!prot_err, "R6 first write clean", int'(prot_err), 0);
    opw(6'd50, 2'd0, 32'h22); tick(); check(prot_err, "R6 double write flagged", int'(prot_err), 1);
    opw(6'd50, 2'd3, 32'h5); tick(); check(prot_err, "R6 reserved index flagged", int'(prot_err), 1);
    opw(6'd50, 2'd1, 32'h33); tick();
    check(!prot_err, "R6 pulse lasts one cycle", int'(prot_err), 0);
    expect_issue(6'd50, "R6 slot still fires");
    check(iss_left == 32'h11, "R6 first value kept", int'(iss_left), 32'h11);
    tick();

    // R5 simultaneous readiness
    load(6'd12, 8'h60, 1, 0, 0, 0); tick();
    opw(6'd12, 2'd0, 32'h7); load(6'd30, 8'h61, 0, 0, 0, 0); tick();
    expect_issue(6'd12, "R5 lower slot first");
    load(6'd7, 8'h62, 0, 0, 0, 0); tick();
    expect_issue(6'd7, "R5 newer lower slot overtakes");
    tick(); expect_issue(6'd30, "R5 remaining slot last");
    tick(); expect_none("R5 window drained");

    // R1 flush discards state and same-cycle traffic
    load(6'd60, 8'h70, 1, 0, 0, 0); tick();
    flush = 1; load(6'd62, 8'h71, 0, 0, 0, 0); opw(6'd61, 2'd0, 32'h9);
    #1 check(!iss_valid, "R1 no issue during flush", int'(iss_valid), 0);
    tick(); expect_none("R1 flushed load discarded");
    opw(6'd60, 2'd0, 32'h8); tick(); expect_none("R1 flushed slot unloaded");
    load(6'd61, 8'h72, 1, 0, 0, 0); tick(); expect_none("R1 flushed operand discarded");
    flush = 1; tick();

    // Random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 63) == 0) flush = 1;
      if ($urandom_range(0, 2) == 0) begin
        load(6'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
             ($urandom_range(0, 3) == 0), 1'($urandom));
        ld_t0_en = 1'($urandom); ld_t0_slot = 6'($urandom); ld_t0_idx = 2'($urandom);
        ld_t1_en = 1'($urandom); ld_t1_slot = 6'($urandom); ld_t1_idx = 2'($urandom);
      end
      if ($urandom_range(0, 1) == 0)
        opw(6'($urandom), ($urandom_range(0, 15) == 0) ? 2'd3 : 2'($urandom_range(0, 2)), $urandom);
      if ($urandom_range(0, 3) == 0) begin
        alu_valid = 1; alu_slot = 6'($urandom); alu_data = $urandom;
      end
      tick();
    end

    running = 0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule